// File: doc/BRIEF.md
# Qualified Event Counter Pair

This block holds two 40-bit programmable event counters. In every clock cycle each counter looks at one source out of a bank of event sources. A source is a group of eight sub-event flags. The low bits of the counter's event code pick the source. The counter's unit mask picks which of that source's flags are counted, so the per-cycle event count is the number of selected flags that are set.

Qualifiers set the amount added to the counter in each cycle:
- With no threshold, the counter adds the full per-cycle count.
- With a threshold, the counter adds one when the count meets the threshold. Inversion flips that compare.
- Edge mode counts only the cycles in which the qualified condition turns true.
- A privilege filter compares the current ring against separate enables for supervisor and user code.

A few event codes may run on only one of the two counters. A configuration write that places such a code on the wrong counter is flagged and leaves that counter disabled. Software reaches the block through a small register port:
- Address 0: control register of counter 0.
- Address 1: control register of counter 1.
- Address 2: count value of counter 0.
- Address 3: count value of counter 1.
- Address 4: status register, write 1 to clear.

A wrap of a counter with its interrupt enable set sets a sticky overflow bit and drives `irq`.

Top module: `evctr_pair`

## Requirements
- R1: After reset both counters, both control registers and the status register read zero, and `irq` is low.
- R2: The per-cycle event count is the number of set bits in (flags of source `evsel[3:0]`) AND (unit mask). The control register fields are:
  - bits [7:0]: event code `evsel`
  - bits [15:8]: unit mask
  - bits [23:16]: threshold
  - bit 24: edge
  - bit 25: invert
  - bit 26: supervisor enable
  - bit 27: user enable
  - bit 28: interrupt enable
  - bit 29: counter enable

  With threshold zero and edge clear, an enabled counter adds the full per-cycle count on each clock.
- R3: With a nonzero threshold and invert clear, the counter adds one in each cycle whose event count is greater than or equal to the threshold, and adds nothing otherwise.
- R4: With a nonzero threshold and invert set, the counter adds one in each cycle whose event count is less than the threshold.
- R5: In edge mode the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. A run of true cycles counts once. With threshold zero, the condition is a nonzero count.
- R6: The ring filter works as follows:
  - Supervisor enable (bit 26) allows counting at `priv_lvl` 0.
  - User enable (bit 27) allows counting at levels 1 to 3.
  - With both bits clear, counting is allowed at every level.
- R7: Placement is restricted for some event codes:
  - Codes 10h, 14h and C1h are legal only on counter 0.
  - Codes 11h, 12h and 13h are legal only on counter 1.

  A control write that breaks this rule sets the error bit of that counter in the status register: bit 2 for counter 0, bit 3 for counter 1. The control register then reads back with enable (bit 29) clear, and the counter does not count.
- R8: A write to a count register in a cycle where the counter also increments loads the written value, and the increment is lost.
- R9: When a counter carries out of bit 39 while its interrupt enable is set, its overflow status bit sets (bit 0 for counter 0, bit 1 for counter 1). The counter keeps the wrapped low 40 bits. `irq` stays high until software writes 1 to that status bit.
- R10: A wrap with interrupt enable clear leaves the status register and `irq` unchanged.
- R11: A counter whose enable bit is clear holds its value whatever the event inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| priv_lvl | input | 2 | Current privilege ring, 0 is the most privileged |
| ev_flags | input | 128 | Sixteen sources of eight sub-event flags; source k is bits [8k+7:8k] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | High while any overflow status bit is set |

## Verification
The bench looks hardest at the qualifier boundaries:
- A count equal to the threshold must count when invert is clear and must not count when invert is set. A comparator that is off by one shifts the totals in both cases.
- A run of true cycles in edge mode must count once. A design that counts levels instead of rises over-counts.
- A misplaced event code must be refused on both counters. A decoder that checks only one direction would let a restricted code run on the wrong counter.

Two further cases are driven:
- A count write that lands in the same cycle as an increment. A design that gives the increment priority returns the written value plus that increment.
- A wrap at 40 bits, driven both with and without interrupt enable. A design that gets this wrong leaves `irq` stuck low, raises it spuriously, or clears it without a software write.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

  // Counter control word, most significant field first.
  typedef struct packed {
    logic       en;      // bit 29
    logic       ie;      // bit 28
    logic       usr;     // bit 27
    logic       os;      // bit 26
    logic       inv;     // bit 25
    logic       edge_m;  // bit 24
    logic [7:0] thresh;  // bits 23:16
    logic [7:0] umask;   // bits 15:8
    logic [7:0] evsel;   // bits 7:0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Which counter an event code is tied to.
  typedef enum logic [1:0] {
    HOME_ANY = 2'd0,
    HOME_C0  = 2'd1,
    HOME_C1  = 2'd2
  } home_e;

  function automatic home_e home_of(input logic [7:0] code);
    case (code)
      8'h10, 8'h14, 8'hC1: home_of = HOME_C0;
      8'h11, 8'h12, 8'h13: home_of = HOME_C1;
      default:             home_of = HOME_ANY;
    endcase
  endfunction

endpackage

// File: rtl/evctr_place.sv
module evctr_place
  import evctr_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [7:0] code,
  output logic       place_ok
);

  home_e home;

  always_comb begin
    home     = home_of(code);
    place_ok = (home == HOME_ANY) ||
               ((home == HOME_C0) && (IDX == 0)) ||
               ((home == HOME_C1) && (IDX == 1));
  end

endmodule

// File: rtl/evctr_select.sv
module evctr_select #(
  parameter int NUM_SRC = 16,
  parameter int SUB_W   = 8,
  parameter int SRC_W   = $clog2(NUM_SRC),
  parameter int CNT_W   = $clog2(SUB_W + 1)
) (
  input  logic [NUM_SRC*SUB_W-1:0] flags,
  input  logic [SRC_W-1:0]         sel,
  input  logic [SUB_W-1:0]         umask,
  output logic [CNT_W-1:0]         ev_cnt
);

  function automatic logic [CNT_W-1:0] ones_in(input logic [SUB_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < SUB_W; k++) acc = acc + CNT_W'(v[k]);
    return acc;
  endfunction

  logic [SUB_W-1:0] picked;

  always_comb begin
    picked = flags[sel*SUB_W +: SUB_W];
    ev_cnt = ones_in(picked & umask);
  end

endmodule

// File: rtl/evctr_qual.sv
module evctr_qual #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             os,
  input  logic             usr,
  input  logic             inv,
  input  logic             edge_m,
  input  logic [7:0]       thresh,
  input  logic [1:0]       priv_lvl,
  input  logic [CNT_W-1:0] ev_cnt,
  output logic [CNT_W-1:0] inc
);

  // Threshold compare; a zero threshold means "any event at all".
  function automatic logic cmp_hit(input logic [7:0] ev, input logic [7:0] thr,
                                   input logic flip);
    if (thr == 8'd0) return ev != 8'd0;
    return flip ? (ev < thr) : (ev >= thr);
  endfunction

  // Ring filter; with neither enable set every ring counts.
  function automatic logic ring_ok(input logic s_en, input logic u_en,
                                   input logic [1:0] lvl);
    logic both_off;
    both_off = !s_en && !u_en;
    return (lvl == 2'd0) ? (s_en || both_off) : (u_en || both_off);
  endfunction

  logic       active;
  logic       cond;
  logic       cond_prev;
  logic       rise;
  logic [7:0] ev8;

  always_comb begin
    ev8    = 8'(ev_cnt);
    active = en && ring_ok(os, usr, priv_lvl);
    cond   = active && cmp_hit(ev8, thresh, inv);
    rise   = cond && !cond_prev;
    if (edge_m)              inc = CNT_W'(rise);
    else if (thresh != 8'd0) inc = CNT_W'(cond);
    else if (active)         inc = ev_cnt;
    else                     inc = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_prev <= 1'b0;
    else        cond_prev <= cond;
  end

  assert_edge_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && cond_prev) |-> (inc == '0));

  assert_thresh_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_m && thresh != 8'd0 && !inv && 8'(ev_cnt) < thresh) |-> (inc == '0));

  assert_ring_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (os && !usr && priv_lvl != 2'd0) |-> (inc == '0));

endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int CTR_W   = 40,
  parameter int NUM_SRC = 16,
  parameter int SUB_W   = 8,
  parameter int SRC_W   = $clog2(NUM_SRC),
  parameter int CNT_W   = $clog2(SUB_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC*SUB_W-1:0] flags,
  input  logic [1:0]               priv_lvl,
  input  logic                     ctrl_we,
  input  logic                     cnt_we,
  input  logic [CTR_W-1:0]         wdata,
  input  logic                     ovf_clr,
  input  logic                     err_clr,
  output ctrl_t                    ctrl_q,
  output logic [CTR_W-1:0]         cnt_q,
  output logic                     ovf_q,
  output logic                     err_q
);

  ctrl_t            ctrl_new;
  logic             place_ok;
  logic [CNT_W-1:0] ev_cnt;
  logic [CNT_W-1:0] inc;
  logic [CTR_W:0]   sum;
  logic             wrap;
  logic             ovf_set;
  logic             err_set;

  assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);

  evctr_place #(.IDX(IDX)) u_place (
    .code     (ctrl_new.evsel),
    .place_ok (place_ok)
  );

  evctr_select #(.NUM_SRC(NUM_SRC), .SUB_W(SUB_W), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_sel (
    .flags  (flags),
    .sel    (ctrl_q.evsel[SRC_W-1:0]),
    .umask  (ctrl_q.umask[SUB_W-1:0]),
    .ev_cnt (ev_cnt)
  );

  evctr_qual #(.CNT_W(CNT_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q.en),
    .os       (ctrl_q.os),
    .usr      (ctrl_q.usr),
    .inv      (ctrl_q.inv),
    .edge_m   (ctrl_q.edge_m),
    .thresh   (ctrl_q.thresh),
    .priv_lvl (priv_lvl),
    .ev_cnt   (ev_cnt),
    .inc      (inc)
  );

  always_comb begin
    sum     = {1'b0, cnt_q} + (CTR_W + 1)'(inc);
    wrap    = sum[CTR_W];
    ovf_set = wrap && ctrl_q.ie && !cnt_we;
    err_set = ctrl_we && !place_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_q    <= ctrl_new;
        ctrl_q.en <= ctrl_new.en && place_ok;
      end
      cnt_q <= cnt_we ? wdata : sum[CTR_W-1:0];
      ovf_q <= ovf_set || (ovf_q && !ovf_clr);
      err_q <= err_set || (err_q && !err_clr);
    end
  end

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata)));

  assert_bad_place_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !place_ok) |=> (!ctrl_q.en && err_q));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  assert_quiet_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.ie && !ovf_q) |=> !ovf_q);

  assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !cnt_we) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/evctr_pair.sv
module evctr_pair
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 2,
  parameter int CTR_W   = 40,
  parameter int NUM_SRC = 16,
  parameter int SUB_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int CNT_W  = $clog2(SUB_W + 1),
  localparam int ADDR_W = $clog2(2 * NUM_CTR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               priv_lvl,
  input  logic [NUM_SRC*SUB_W-1:0] ev_flags,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [CTR_W-1:0]         reg_wdata,
  output logic [CTR_W-1:0]         reg_rdata,
  output logic                     irq
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * NUM_CTR);

  ctrl_t                   ctrl_q [NUM_CTR];
  logic [CTR_W-1:0]        cnt_q  [NUM_CTR];
  logic [NUM_CTR-1:0]      ovf_vec;
  logic [NUM_CTR-1:0]      err_vec;
  logic                    stat_we;

  assign stat_we = reg_we && (reg_addr == STAT_ADDR);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic ctrl_we_i;
    logic cnt_we_i;
    assign ctrl_we_i = reg_we && (reg_addr == ADDR_W'(i));
    assign cnt_we_i  = reg_we && (reg_addr == ADDR_W'(NUM_CTR + i));

    evctr_unit #(
      .IDX(i), .CTR_W(CTR_W), .NUM_SRC(NUM_SRC), .SUB_W(SUB_W),
      .SRC_W(SRC_W), .CNT_W(CNT_W)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (ev_flags),
      .priv_lvl (priv_lvl),
      .ctrl_we  (ctrl_we_i),
      .cnt_we   (cnt_we_i),
      .wdata    (reg_wdata),
      .ovf_clr  (stat_we && reg_wdata[i]),
      .err_clr  (stat_we && reg_wdata[NUM_CTR + i]),
      .ctrl_q   (ctrl_q[i]),
      .cnt_q    (cnt_q[i]),
      .ovf_q    (ovf_vec[i]),
      .err_q    (err_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(i))           reg_rdata = CTR_W'(ctrl_q[i]);
      if (reg_addr == ADDR_W'(NUM_CTR + i)) reg_rdata = cnt_q[i];
    end
    if (reg_addr == STAT_ADDR) reg_rdata = CTR_W'({err_vec, ovf_vec});
  end

  assign irq = |ovf_vec;

endmodule

// File: tb/evctr_pair_test.sv
module evctr_pair_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   priv_lvl;
  logic [127:0] ev_flags;
  logic         reg_we;
  logic [2:0]   reg_addr;
  logic [39:0]  reg_wdata;
  logic [39:0]  reg_rdata;
  logic         irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  evctr_pair uut (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .ev_flags(ev_flags),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [2:0] A_C0 = 3'd0, A_C1 = 3'd1, A_N0 = 3'd2, A_N1 = 3'd3, A_ST = 3'd4;

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] cw(input logic [7:0] code, input logic [7:0] um,
      input logic [7:0] thr, input bit ed, input bit iv, input bit s, input bit u,
      input bit ie, input bit en);
    return {10'd0, en, ie, u, s, iv, ed, thr, um, code};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [39:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [39:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input int src, input logic [7:0] v);
    ev_flags[src*8 +: 8] = v;
    @(negedge clk);
  endtask

  task automatic prep(input logic [2:0] ca, input logic [2:0] na, input logic [39:0] start);
    ev_flags = '0;
    wr(ca, 40'd0);
    wr(na, start);
  endtask

  task automatic t_reset;
    logic [39:0] d;
    rd(A_C0, d); check("R1 ctrl0", d, 40'd0);
    rd(A_C1, d); check("R1 ctrl1", d, 40'd0);
    rd(A_N0, d); check("R1 cnt0", d, 40'd0);
    rd(A_N1, d); check("R1 cnt1", d, 40'd0);
    rd(A_ST, d); check("R1 status", d, 40'd0);
    check("R1 irq", 40'(irq), 40'd0);
  endtask

  task automatic t_full_count;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'h0F, 8'd0, 0, 0, 0, 0, 0, 1));
    for (int i = 0; i < 3; i++) drive(5, 8'hFF);     // 4 per cycle
    drive(5, 8'h00);
    rd(A_N0, d); check("R2 umask 0F", d, 40'(3 * $countones(8'hFF & 8'h0F)));
    wr(A_C0, cw(8'h25, 8'hF0, 8'd0, 0, 0, 0, 0, 0, 1));
    for (int i = 0; i < 2; i++) drive(5, 8'hAA);     // 2 per cycle
    drive(5, 8'h00);
    rd(A_N0, d); check("R2 umask F0", d, 40'(12 + 2 * $countones(8'hAA & 8'hF0)));
  endtask

  task automatic t_thresh;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'hFF, 8'd3, 0, 0, 0, 0, 0, 1));
    drive(5, 8'h0F); drive(5, 8'h03); drive(5, 8'h07); drive(5, 8'h1F);
    drive(5, 8'h00);
    rd(A_N0, d); check("R3 ge threshold", d, 40'd3);     // 4,3,5 count; 2 does not
  endtask

  task automatic t_invert;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'd0);
    ev_flags[5*8 +: 8] = 8'hFF;
    wr(A_C0, cw(8'h25, 8'hFF, 8'd3, 0, 1, 0, 0, 0, 1));
    drive(5, 8'h0F); drive(5, 8'h03); drive(5, 8'h07); drive(5, 8'h1F);
    ev_flags[5*8 +: 8] = 8'hFF;
    wr(A_C0, 40'd0);
    rd(A_N0, d); check("R4 below threshold", d, 40'd1);  // only the count of 2
  endtask

  task automatic t_edge;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'hFF, 8'd2, 1, 0, 0, 0, 0, 1));
    drive(5, 8'h07); drive(5, 8'h07); drive(5, 8'h07); drive(5, 8'h00);
    drive(5, 8'h0F); drive(5, 8'h0F); drive(5, 8'h01); drive(5, 8'h03);
    drive(5, 8'h00); drive(5, 8'h00);
    rd(A_N0, d); check("R5 rising edges", d, 40'd3);
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 1));
    for (int i = 0; i < 4; i++) drive(5, 8'hFF);
    drive(5, 8'h00);
    rd(A_N0, d); check("R5 edge zero threshold", d, 40'd1);
  endtask

  task automatic t_ring;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'h01, 8'd0, 0, 0, 1, 0, 0, 1));
    priv_lvl = 2'd0; drive(5, 8'h01); drive(5, 8'h01);
    priv_lvl = 2'd2; for (int i = 0; i < 3; i++) drive(5, 8'h01);
    priv_lvl = 2'd3; drive(5, 8'h01);
    drive(5, 8'h00);
    rd(A_N0, d); check("R6 supervisor only", d, 40'd2);
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'h01, 8'd0, 0, 0, 0, 1, 0, 1));
    priv_lvl = 2'd0; drive(5, 8'h01); drive(5, 8'h01);
    priv_lvl = 2'd1; for (int i = 0; i < 3; i++) drive(5, 8'h01);
    drive(5, 8'h00);
    rd(A_N0, d); check("R6 user only", d, 40'd3);
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1));
    priv_lvl = 2'd3; for (int i = 0; i < 4; i++) drive(5, 8'h01);
    priv_lvl = 2'd0; for (int i = 0; i < 2; i++) drive(5, 8'h01);
    drive(5, 8'h00);
    rd(A_N0, d); check("R6 both clear", d, 40'd6);
    priv_lvl = 2'd0;
  endtask

  task automatic t_place;
    logic [39:0] d;
    wr(A_ST, 40'hF);
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h13, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1));
    rd(A_ST, d); check("R7 err0 on 13h", d, 40'h4);
    rd(A_C0, d); check("R7 ctrl0 enable dropped", d, cw(8'h13, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) drive(3, 8'hFF);
    drive(3, 8'h00);
    rd(A_N0, d); check("R7 cnt0 idle", d, 40'd0);
    prep(A_C1, A_N1, 40'd0);
    wr(A_C1, cw(8'h14, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1));
    rd(A_ST, d); check("R7 err1 on 14h", d, 40'hC);
    wr(A_ST, 40'hC);
    wr(A_C1, cw(8'h13, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1));
    rd(A_ST, d); check("R7 13h legal on ctr1", d, 40'h0);
    drive(3, 8'hFF); drive(3, 8'hFF);
    drive(3, 8'h00);
    rd(A_N1, d); check("R7 ctr1 counts 13h", d, 40'd2);
    wr(A_C1, 40'd0);
    wr(A_C1, cw(8'hC1, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1));
    rd(A_ST, d); check("R7 err1 on C1h", d, 40'h8);
    wr(A_ST, 40'hC);
  endtask

  task automatic t_write_prio;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'd0);
    wr(A_C0, cw(8'h25, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1));
    ev_flags[5*8 +: 8] = 8'hFF;
    wr(A_N0, 40'd100);
    ev_flags = '0;
    rd(A_N0, d); check("R8 write beats increment", d, 40'd100);
    wr(A_C0, 40'd0);
  endtask

  task automatic t_wrap_irq;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'hFF_FFFF_FFFE);
    wr(A_C0, cw(8'h25, 8'hFF, 8'd0, 0, 0, 0, 0, 1, 1));
    drive(5, 8'h07);
    ev_flags = '0;
    rd(A_N0, d); check("R9 wrapped value", d, 40'd1);
    rd(A_ST, d); check("R9 overflow bit", d, 40'h1);
    check("R9 irq set", 40'(irq), 40'd1);
    wr(A_C0, 40'd0);
    repeat (5) @(negedge clk);
    check("R9 irq held", 40'(irq), 40'd1);
    wr(A_ST, 40'h1);
    check("R9 irq cleared", 40'(irq), 40'd0);
    rd(A_ST, d); check("R9 status cleared", d, 40'h0);
  endtask

  task automatic t_wrap_quiet;
    logic [39:0] d;
    prep(A_C1, A_N1, 40'hFF_FFFF_FFFE);
    wr(A_C1, cw(8'h25, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1));
    drive(5, 8'h07);
    ev_flags = '0;
    rd(A_N1, d); check("R10 wrapped value", d, 40'd1);
    rd(A_ST, d); check("R10 no status", d, 40'h0);
    check("R10 irq low", 40'(irq), 40'd0);
    wr(A_C1, 40'd0);
  endtask

  task automatic t_disabled;
    logic [39:0] d;
    prep(A_C0, A_N0, 40'h55);
    wr(A_C0, cw(8'h25, 8'hFF, 8'd0, 0, 0, 0, 0, 1, 0));
    for (int i = 0; i < 3; i++) drive(5, 8'hFF);
    ev_flags = '0;
    rd(A_N0, d); check("R11 disabled holds", d, 40'h55);
  endtask

  initial begin
    rst_n = 1'b0; priv_lvl = 2'd0; ev_flags = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_count();
    t_thresh();
    t_invert();
    t_edge();
    t_ring();
    t_place();
    t_write_prio();
    t_wrap_irq();
    t_wrap_quiet();
    t_disabled();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule